// File: doc/BRIEF.md
# SCSI Target Bus Phase Sequencer

This block sets the three information-transfer phase lines (message, control/data, input/output) that a SCSI target drives on the bus. A controller asks for a phase by pulsing `req_valid` with a 4-bit phase code. The sequencer waits until the initiator has let go of ACK, because a phase may not change while a handshake is open. It then drives the new phase and holds `busy` for a fixed settle time before it reports, with a single-cycle `ready_pulse`, that the bus may be used. A pending wait for ACK is cut short when the bus reset flag is raised.

The phase code has a release encoding. When it is requested, the three phase lines are tri-stated instead of driven. A request for the phase already in force is accepted, completes at once, costs no settle time and gives no ready pulse. A separate bus-free command returns the block straight to the released state. It cancels whatever request or settle period is in progress.

The settle length is computed from a clock-frequency parameter and a settle time in nanoseconds. Their defaults give 100 µs at 250 MHz.

Top module: `scsi_phase_seq`

## Requirements
- R1: After reset `cur_phase` is 4'b1000 (released), `phase_oe` is 3'b000, all three phase lines are 0, and `busy` and `ready_pulse` are 0.
- R2: While `cur_phase[3]` is 0, `msg_o` equals `cur_phase[2]`, `cd_o` equals `cur_phase[1]`, `io_o` equals `cur_phase[0]`, and `phase_oe` is 3'b111.
- R3: A requested code with bit 3 set is the release value. When it takes effect, `cur_phase` becomes 4'b1000, `phase_oe` becomes 3'b000 and the three lines read 0.
- R4: While `ack_in` is 1 and `reset_flag` is 0, an accepted request is held and `cur_phase` does not change.
- R5: When `reset_flag` is 1, a held request takes effect even though `ack_in` is 1.
- R6: A request for the phase already in force leaves `cur_phase` unchanged. `busy` is 1 for exactly one cycle, and no `ready_pulse` follows.
- R7: A request that changes the phase is accepted on edge E and takes effect on edge E+1 when ACK is clear. `busy` then stays 1 until edge E+N+1, where N = CLK_HZ/1000·SETTLE_NS/10^6 cycles. On that edge `ready_pulse` rises for one cycle and `busy` falls.
- R8: A `req_valid` pulse while `busy` is 1 is ignored, and the phase reached is that of the first request.
- R9: `bus_free_cmd` takes priority over everything, including a `req_valid` in the same cycle. On the next edge `cur_phase` becomes 4'b1000, `busy` is 0, any settle period is cancelled and it produces no `ready_pulse`.
- R10: With no request and no bus-free command, `cur_phase` holds its value while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle phase request strobe |
| req_code | input | 4 | Requested phase; bit 3 = release, bits 2..0 = MSG, C/D, I/O |
| bus_free_cmd | input | 1 | Return to bus free now |
| ack_in | input | 1 | Initiator ACK line, 1 = asserted |
| reset_flag | input | 1 | Bus reset seen; overrides the ACK wait |
| msg_o | output | 1 | MSG line value |
| cd_o | output | 1 | C/D line value |
| io_o | output | 1 | I/O line value |
| phase_oe | output | 3 | Output enables {MSG, C/D, I/O} |
| busy | output | 1 | Request held or settle in progress |
| ready_pulse | output | 1 | One-cycle pulse at the end of a settle period |
| cur_phase | output | 4 | Phase now in force |

## Verification
The cases that are hardest to reach from the ports are a bus-free command that lands partway through a settle period, and a second request that arrives while the first is still waiting for ACK or settling. To reach them, the bench starts a real phase change and counts a known number of cycles into the settle window before it pulses the command or the competing request. It then watches the full remaining window to confirm that no ready pulse ever appears and that the phase is the one the requirement predicts. ACK hold-off is reached the same way: ACK is raised before a request, held for many cycles, and released on a chosen edge, so the bench can pin down the exact cycle on which the phase changes.

// File: rtl/scsi_phase_pkg.sv
package scsi_phase_pkg;

  typedef logic [3:0] phase_t;

  localparam phase_t PHASE_RELEASED = 4'b1000;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HOLD   = 2'd1,
    ST_SETTLE = 2'd2
  } seq_state_t;

  // Settle length in clock cycles, never below one.
  function automatic int unsigned settle_cycles(longint unsigned clk_hz,
                                                longint unsigned settle_ns);
    longint unsigned cyc;
    cyc = ((clk_hz / 64'd1000) * settle_ns) / 64'd1000000;
    if (cyc == 64'd0) cyc = 64'd1;
    return int'(cyc);
  endfunction

  // Any code with the top bit set collapses to the single released value.
  function automatic phase_t normalize(phase_t code);
    return code[3] ? PHASE_RELEASED : {1'b0, code[2:0]};
  endfunction

  // Values placed on {MSG, C/D, I/O}; zero while released.
  function automatic logic [2:0] line_values(phase_t ph);
    return ph[3] ? 3'b000 : ph[2:0];
  endfunction

endpackage

// File: rtl/phase_settle_timer.sv
module phase_settle_timer
  import scsi_phase_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic running,
  output logic expire
);

  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (abort) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= LOAD_VAL;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign running = run_q;
  assign expire  = run_q && (cnt_q == '0);

endmodule

// File: rtl/phase_seq_fsm.sv
module phase_seq_fsm
  import scsi_phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_valid,
  input  phase_t req_code,
  input  logic   bus_free_cmd,
  input  logic   ack_in,
  input  logic   reset_flag,
  input  logic   settle_expire,
  output phase_t cur_phase,
  output logic   busy,
  output logic   ready_pulse,
  output logic   accept_req,
  output logic   apply_change,
  output logic   same_phase_done
);

  seq_state_t state_q;
  phase_t     cur_q;
  phase_t     pend_q;
  logic       ready_q;
  logic       hold_clear;
  logic       in_hold;

  assign in_hold         = (state_q == ST_HOLD);
  assign hold_clear      = !ack_in || reset_flag;
  assign accept_req      = (state_q == ST_IDLE) && req_valid && !bus_free_cmd;
  assign apply_change    = in_hold && hold_clear && !bus_free_cmd && (pend_q != cur_q);
  assign same_phase_done = in_hold && hold_clear && !bus_free_cmd && (pend_q == cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= PHASE_RELEASED;
      pend_q  <= PHASE_RELEASED;
      ready_q <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      if (bus_free_cmd) begin
        state_q <= ST_IDLE;
        cur_q   <= PHASE_RELEASED;
        pend_q  <= PHASE_RELEASED;
      end else begin
        unique case (state_q)
          ST_IDLE: begin
            if (accept_req) begin
              pend_q  <= normalize(req_code);
              state_q <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            if (apply_change) begin
              cur_q   <= pend_q;
              state_q <= ST_SETTLE;
            end else if (same_phase_done) begin
              state_q <= ST_IDLE;
            end
          end
          ST_SETTLE: begin
            if (settle_expire) begin
              state_q <= ST_IDLE;
              ready_q <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign cur_phase   = cur_q;
  assign busy        = (state_q != ST_IDLE);
  assign ready_pulse = ready_q;

endmodule

// File: rtl/phase_line_drive.sv
module phase_line_drive
  import scsi_phase_pkg::*;
#(
  parameter int LINES = 3
) (
  input  phase_t           cur_phase,
  output logic [LINES-1:0] line_val,
  output logic [LINES-1:0] line_oe
);

  logic [2:0] vals;
  assign vals = line_values(cur_phase);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign line_val[i] = vals[i];
    assign line_oe[i]  = ~cur_phase[3];
  end

endmodule

// File: rtl/scsi_phase_seq.sv
module scsi_phase_seq
  import scsi_phase_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 250000000,
  parameter longint unsigned SETTLE_NS = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [3:0] req_code,
  input  logic       bus_free_cmd,
  input  logic       ack_in,
  input  logic       reset_flag,
  output logic       msg_o,
  output logic       cd_o,
  output logic       io_o,
  output logic [2:0] phase_oe,
  output logic       busy,
  output logic       ready_pulse,
  output logic [3:0] cur_phase
);

  localparam int unsigned SETTLE_CYC = settle_cycles(CLK_HZ, SETTLE_NS);

  logic       settle_expire;
  logic       settle_running;
  logic       accept_req;
  logic       apply_change;
  logic       same_phase_done;
  phase_t     cur_q;
  logic [2:0] line_val;

  phase_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_code       (req_code),
    .bus_free_cmd   (bus_free_cmd),
    .ack_in         (ack_in),
    .reset_flag     (reset_flag),
    .settle_expire  (settle_expire),
    .cur_phase      (cur_q),
    .busy           (busy),
    .ready_pulse    (ready_pulse),
    .accept_req     (accept_req),
    .apply_change   (apply_change),
    .same_phase_done(same_phase_done)
  );

  phase_settle_timer #(
    .SETTLE_CYC(SETTLE_CYC)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (apply_change),
    .abort  (bus_free_cmd),
    .running(settle_running),
    .expire (settle_expire)
  );

  phase_line_drive #(
    .LINES(3)
  ) u_drive (
    .cur_phase(cur_q),
    .line_val (line_val),
    .line_oe  (phase_oe)
  );

  assign msg_o     = line_val[2];
  assign cd_o      = line_val[1];
  assign io_o      = line_val[0];
  assign cur_phase = cur_q;

endmodule

// File: rtl/scsi_phase_seq_chk.sv
module scsi_phase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       bus_free_cmd,
  input logic       ack_in,
  input logic       reset_flag,
  input logic       msg_o,
  input logic       cd_o,
  input logic       io_o,
  input logic [2:0] phase_oe,
  input logic       busy,
  input logic       ready_pulse,
  input logic [3:0] cur_phase,
  input logic       apply_change,
  input logic       same_phase_done,
  input logic       settle_running
);

  AST_ACK_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && !reset_flag && !bus_free_cmd) |=> (cur_phase == $past(cur_phase))); // R4

  AST_RELEASED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_oe == 3'b000) |-> ({msg_o, cd_o, io_o} == 3'b000)); // R3

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |=> !ready_pulse); // R7

  AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_pulse |-> !busy); // R7

  AST_CHANGE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    apply_change |=> (busy && settle_running)); // R7

  AST_SAME_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    same_phase_done |=> (!busy && !settle_running)); // R6

  AST_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free_cmd |=> (cur_phase == 4'b1000 && !busy && !ready_pulse)); // R9

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid && !bus_free_cmd) |=> $stable(cur_phase)); // R10

endmodule

bind scsi_phase_seq scsi_phase_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .bus_free_cmd   (bus_free_cmd),
  .ack_in         (ack_in),
  .reset_flag     (reset_flag),
  .msg_o          (msg_o),
  .cd_o           (cd_o),
  .io_o           (io_o),
  .phase_oe       (phase_oe),
  .busy           (busy),
  .ready_pulse    (ready_pulse),
  .cur_phase      (cur_phase),
  .apply_change   (apply_change),
  .same_phase_done(same_phase_done),
  .settle_running (settle_running)
);

// File: tb/scsi_phase_seq_tb.sv
module scsi_phase_seq_tb;

  localparam longint unsigned TB_CLK_HZ = 1000000;
  localparam longint unsigned TB_NS     = 100000;
  localparam int N = 100; // 1000 kHz-units * 100000 ns / 1e6

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [3:0] req_code = 4'h0;
  logic       bus_free_cmd = 1'b0;
  logic       ack_in = 1'b0;
  logic       reset_flag = 1'b0;
  logic       msg_o, cd_o, io_o, busy, ready_pulse;
  logic [2:0] phase_oe;
  logic [3:0] cur_phase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [3:0] mcur = 4'b1000;

  localparam logic [3:0] VEC [10] = '{4'h0, 4'h1, 4'h1, 4'h2, 4'h7, 4'hF,
                                      4'h8, 4'h3, 4'h6, 4'h6};

  always #2 clk = ~clk;

  scsi_phase_seq #(.CLK_HZ(TB_CLK_HZ), .SETTLE_NS(TB_NS)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .bus_free_cmd(bus_free_cmd), .ack_in(ack_in), .reset_flag(reset_flag),
    .msg_o(msg_o), .cd_o(cd_o), .io_o(io_o), .phase_oe(phase_oe),
    .busy(busy), .ready_pulse(ready_pulse), .cur_phase(cur_phase)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_lines(string req, logic [3:0] ph);
    chk(req, {28'd0, cur_phase}, {28'd0, ph});
    if (ph[3]) begin
      chk(req, {29'd0, phase_oe}, 32'd0);
      chk(req, {29'd0, msg_o, cd_o, io_o}, 32'd0);
    end else begin
      chk(req, {29'd0, phase_oe}, 32'd7);
      chk(req, {29'd0, msg_o, cd_o, io_o}, {29'd0, ph[2:0]});
    end
  endtask

  function automatic logic [3:0] norm(logic [3:0] c);
    return c[3] ? 4'b1000 : {1'b0, c[2:0]};
  endfunction

  task automatic pulse_req(logic [3:0] code);
    @(negedge clk); req_valid = 1'b1; req_code = code;
    @(negedge clk); req_valid = 1'b0;
  endtask

  // Request with ACK clear; full timing check.
  task automatic run_req(logic [3:0] code);
    logic [3:0] tgt;
    logic chg;
    tgt = norm(code);
    chg = (tgt != mcur);
    pulse_req(code);
    chk("R7 busy after accept", {31'd0, busy}, 32'd1);
    @(negedge clk);
    if (chg) begin
      mcur = tgt;
      chk_lines(tgt[3] ? "R3 release" : "R2 lines", mcur);
      chk("R7 busy in settle", {31'd0, busy}, 32'd1);
      repeat (N - 1) @(negedge clk);
      chk("R7 still settling", {30'd0, busy, ready_pulse}, 32'd2);
      @(negedge clk);
      chk("R7 ready at end", {30'd0, busy, ready_pulse}, 32'd1);
      @(negedge clk);
      chk("R7 ready one cycle", {31'd0, ready_pulse}, 32'd0);
    end else begin
      chk_lines("R6 same phase", mcur);
      chk("R6 no settle", {30'd0, busy, ready_pulse}, 32'd0);
      repeat (3) @(negedge clk);
      chk("R6 no ready", {30'd0, busy, ready_pulse}, 32'd0);
    end
  endtask

  task automatic finish_settle();
    int cnt = 0;
    while (!ready_pulse && cnt < N + 20) begin
      @(negedge clk);
      cnt++;
    end
    chk("R7 ready seen", {31'd0, ready_pulse}, 32'd1);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_lines("R1 reset", 4'b1000);
    chk("R1 reset flags", {30'd0, busy, ready_pulse}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle hold", {28'd0, cur_phase}, 32'h8);

    for (int i = 0; i < 10; i++) run_req(VEC[i]);

    // R4: ACK held high keeps the request pending.
    ack_in = 1'b1;
    pulse_req(4'h5);
    repeat (20) @(negedge clk);
    chk_lines("R4 held by ack", mcur);
    chk("R4 busy while held", {31'd0, busy}, 32'd1);
    ack_in = 1'b0;
    @(negedge clk);
    mcur = 4'h5;
    chk_lines("R4 after ack drop", mcur);
    finish_settle();

    // R5: reset flag overrides ACK.
    ack_in = 1'b1; reset_flag = 1'b1;
    pulse_req(4'h2);
    @(negedge clk);
    mcur = 4'h2;
    chk_lines("R5 reset overrides ack", mcur);
    finish_settle();
    ack_in = 1'b0; reset_flag = 1'b0;

    // R8: a second request during settle is dropped.
    pulse_req(4'h4);
    repeat (10) @(negedge clk);
    pulse_req(4'h1);
    mcur = 4'h4;
    finish_settle();
    repeat (5) @(negedge clk);
    chk_lines("R8 second request ignored", mcur);
    chk("R8 no further busy", {31'd0, busy}, 32'd0);

    // R9: bus-free partway through settle.
    pulse_req(4'h3);
    repeat (30) @(negedge clk);
    bus_free_cmd = 1'b1;
    @(negedge clk);
    bus_free_cmd = 1'b0;
    mcur = 4'b1000;
    chk_lines("R9 bus free aborts", mcur);
    chk("R9 not busy", {31'd0, busy}, 32'd0);
    begin
      int seen = 0;
      for (int k = 0; k < N + 10; k++) begin
        @(negedge clk);
        if (ready_pulse) seen++;
      end
      chk("R9 no ready after abort", seen, 0);
    end

    // R9: bus-free beats a simultaneous request.
    run_req(4'h6);
    @(negedge clk);
    bus_free_cmd = 1'b1; req_valid = 1'b1; req_code = 4'h1;
    @(negedge clk);
    bus_free_cmd = 1'b0; req_valid = 1'b0;
    chk_lines("R9 priority over request", 4'b1000);
    repeat (5) @(negedge clk);
    chk("R9 request dropped", {30'd0, busy, ready_pulse}, 32'd0);
    chk("R10 idle hold after", {28'd0, cur_phase}, 32'h8);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule